// File: doc/BRIEF.md
# Receive Descriptor Ring

This block is the receive end of a network MAC that passes incoming frames to software through a ring of buffer descriptors. Each descriptor is a 16-bit word with a small data buffer attached. A single ownership flag in each word decides who holds the buffer. Software sets the flag to give a descriptor to hardware. When hardware has filled the buffer, it clears the flag to give the descriptor back.

Frames arrive as single-cycle strobes that carry a length and up to two bytes of payload. The block keeps a ring pointer that names the next descriptor to fill. If that descriptor is owned by hardware, the payload goes into its buffer, the pointer moves on, and a receive interrupt source latches. If the descriptor is still owned by software, the frame is discarded and a busy source latches instead.

Interrupt sources latch whatever the mask says, and the interrupt output is the OR of the sources that are both set and unmasked. Because of this, software can move from polling to interrupt mode without losing a frame that lands during the switch. Enabling the receiver while no descriptor is owned by hardware raises an error source.

Top module: `rxr_ring_top`

## Requirements
- R1: After reset the ring pointer is 0, all interrupt sources and the mask are 0, the interrupt output is low, and every descriptor word and buffer reads 0.
- R2: A software write stores a full 16-bit word into the descriptor at the given address. The descriptor and its buffer are read combinationally at the same address. Bit 15 of a descriptor is the empty flag: 1 means hardware owns the buffer.
- R3: A frame strobe with the receiver enabled and the descriptor at the ring pointer empty does the following. It writes the payload into that buffer and zeroes the bytes beyond the stored length. It writes min(length, 2) into descriptor bits [1:0], keeps bits [14:2], and clears bit 15, all visible one cycle after the strobe.
- R4: Each stored frame advances the ring pointer by one in index order, wrapping from the last descriptor to 0.
- R5: A frame strobe that finds the descriptor at the pointer not empty is dropped. Interrupt source bit 1 (busy) sets, and the pointer and that descriptor stay unchanged.
- R6: Frame strobes while the receiver enable is low are ignored: no descriptor, buffer, pointer or source changes.
- R7: Interrupt source bit 0 (receive) sets on every stored frame whether or not it is masked. The interrupt output is high exactly when some source bit and the matching mask bit are both 1.
- R8: Writing 1 to a source bit clears it and writing 0 leaves it. A set event in the same cycle as a clear of that bit leaves the bit at 1.
- R9: A rising edge of the receiver enable while no descriptor is empty sets interrupt source bit 2 (error). A rising edge with at least one descriptor empty does not set it.
- R10: A mask write loads the 3-bit mask, which takes effect on the interrupt output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable level |
| frm_valid | input | 1 | One-cycle frame arrival strobe |
| frm_len | input | 2 | Frame length in bytes |
| frm_data | input | 16 | Frame payload, byte 0 in bits [7:0] |
| sw_addr | input | 3 | Descriptor index for software access |
| sw_we | input | 1 | Software descriptor write strobe |
| sw_wdata | input | 16 | Descriptor write data |
| sw_rdata | output | 16 | Descriptor word at sw_addr |
| sw_buf_rdata | output | 16 | Buffer contents at sw_addr |
| irq_clr_we | input | 1 | Write-one-to-clear strobe for the sources |
| irq_clr_data | input | 3 | Source bits to clear |
| irq_mask_we | input | 1 | Mask write strobe |
| irq_mask_data | input | 3 | New mask value |
| irq_src | output | 3 | Latched sources: bit0 receive, bit1 busy, bit2 error |
| irq | output | 1 | Interrupt request |
| rx_ptr | output | 3 | Ring pointer to the next descriptor to fill |

## Verification
The bench builds the block with its default parameters: eight descriptors and two-byte buffers. With only eight entries, a short run can fill the ring completely, wrap the pointer, and run into a descriptor still owned by software, so the drop, busy and wrap corners are all exercised. Two-byte buffers mean that frame lengths 0 through 3 cover a short frame, an exact fit and a clamped oversize frame. The tests also drive a clear in the same cycle as a frame store, and raise the enable with the ring both fully owned by software and partly armed.

// File: rtl/rxr_pkg.sv
// Shared constants for the receive descriptor ring.
// Assumes a 16-bit descriptor word with the ownership flag in the top bit.
package rxr_pkg;
    localparam int DESC_W    = 16;
    localparam int EMPTY_BIT = 15;
    localparam int SRC_W     = 3;
    localparam int SRC_RX    = 0;
    localparam int SRC_BUSY  = 1;
    localparam int SRC_ERR   = 2;
endpackage

// File: rtl/rxr_desc_store.sv
// Descriptor words and their frame buffers.
// Assumes at most one hardware store per cycle. A hardware store wins over a
// software write to the same index in the same cycle.
module rxr_desc_store #(
    parameter int NUM_DESC  = 8,
    parameter int BUF_BYTES = 2,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
    localparam int LEN_W    = $clog2(BUF_BYTES + 1),
    localparam int DATA_W   = BUF_BYTES * 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sw_we,
    input  logic [IDX_W-1:0]          sw_addr,
    input  logic [rxr_pkg::DESC_W-1:0] sw_wdata,
    output logic [rxr_pkg::DESC_W-1:0] sw_rdata,
    output logic [DATA_W-1:0]         sw_buf_rdata,
    input  logic                      hw_we,
    input  logic [IDX_W-1:0]          hw_idx,
    input  logic [LEN_W-1:0]          hw_len,
    input  logic [DATA_W-1:0]         hw_data,
    output logic [NUM_DESC-1:0]       empty_vec
);
    import rxr_pkg::*;

    logic [DESC_W-1:0] desc_q [NUM_DESC];
    logic [DATA_W-1:0] buf_q  [NUM_DESC];

    for (genvar i = 0; i < NUM_DESC; i++) begin : g_entry
        // Update one descriptor and its buffer from hardware or software.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                desc_q[i] <= '0;
                buf_q[i]  <= '0;
            end else if (hw_we && hw_idx == IDX_W'(i)) begin
                desc_q[i] <= {1'b0, desc_q[i][EMPTY_BIT-1:LEN_W], hw_len};
                buf_q[i]  <= hw_data;
            end else if (sw_we && sw_addr == IDX_W'(i)) begin
                desc_q[i] <= sw_wdata;
            end
        end
        assign empty_vec[i] = desc_q[i][EMPTY_BIT];
    end

    // Combinational software read port.
    always_comb begin
        sw_rdata     = desc_q[sw_addr];
        sw_buf_rdata = buf_q[sw_addr];
    end

    // R3
    // hand_back_chk
    hand_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_we |=> !empty_vec[$past(hw_idx)]);

    // R2
    // sw_arm_chk
    sw_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !hw_we && sw_wdata[EMPTY_BIT]) |=> empty_vec[$past(sw_addr)]);
endmodule

// File: rtl/rxr_ring_ctrl.sv
// Ring pointer and frame admission.
// Decides store or drop for each frame strobe, clamps the length to the buffer
// size, masks unused payload bytes, and flags an enable with no empty entry.
// Assumes frm_valid is a one-cycle strobe per frame.
module rxr_ring_ctrl #(
    parameter int NUM_DESC  = 8,
    parameter int BUF_BYTES = 2,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
    localparam int LEN_W    = $clog2(BUF_BYTES + 1),
    localparam int DATA_W   = BUF_BYTES * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                frm_valid,
    input  logic [LEN_W-1:0]    frm_len,
    input  logic [DATA_W-1:0]   frm_data,
    input  logic [NUM_DESC-1:0] empty_vec,
    output logic                store_o,
    output logic                drop_o,
    output logic                en_err_o,
    output logic [IDX_W-1:0]    ptr_o,
    output logic [LEN_W-1:0]    len_o,
    output logic [DATA_W-1:0]   data_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);
    localparam logic [LEN_W-1:0] MAX_LEN  = LEN_W'(BUF_BYTES);

    logic [IDX_W-1:0] ptr_q;
    logic             en_q;
    logic             take;

    // Decide whether this cycle's frame is stored or dropped.
    always_comb begin
        take    = frm_valid && rx_en;
        store_o = take && empty_vec[ptr_q];
        drop_o  = take && !empty_vec[ptr_q];
        len_o   = (frm_len > MAX_LEN) ? MAX_LEN : frm_len;
    end

    for (genvar b = 0; b < BUF_BYTES; b++) begin : g_byte
        assign data_o[b*8 +: 8] = (LEN_W'(b) < len_o) ? frm_data[b*8 +: 8] : 8'h00;
    end

    // Advance the ring pointer on each stored frame, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (store_o)
            ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
    end

    // Remember the previous enable level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= rx_en;
    end

    assign en_err_o = rx_en && !en_q && !(|empty_vec);
    assign ptr_o    = ptr_q;

    // R5
    // drop_hold_chk
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |=> $stable(ptr_o));

    // R6
    // idle_hold_chk
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> $stable(ptr_o));

    // R4
    // advance_chk
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_o && NUM_DESC > 1) |=> (ptr_o != $past(ptr_o)));
endmodule

// File: rtl/rxr_irq_ctrl.sv
// Interrupt source latches, write-one-to-clear, and mask.
// Assumes set events are single-cycle pulses. A set wins over a clear of the
// same bit in the same cycle.
module rxr_irq_ctrl (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [rxr_pkg::SRC_W-1:0] set_i,
    input  logic                      clr_we,
    input  logic [rxr_pkg::SRC_W-1:0] clr_data,
    input  logic                      mask_we,
    input  logic [rxr_pkg::SRC_W-1:0] mask_data,
    output logic [rxr_pkg::SRC_W-1:0] src_o,
    output logic                      irq_o
);
    import rxr_pkg::*;

    logic [SRC_W-1:0] src_q;
    logic [SRC_W-1:0] mask_q;
    logic [SRC_W-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_data : '0;

    // Latch sources, clear on write-one, let set events win.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= (src_q & ~clr_eff) | set_i;
    end

    // Hold the mask written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_data;
    end

    assign src_o = src_q;
    assign irq_o = |(src_q & mask_q);

    // R7
    // rx_latch_chk
    rx_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[SRC_RX] |=> src_o[SRC_RX]);

    // R8
    // clear_wins_chk
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_data[SRC_RX] && !set_i[SRC_RX]) |=> !src_o[SRC_RX]);

    // R7
    // masked_quiet_chk
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_we && $past(mask_we) && mask_data == '0 && $past(mask_data) == '0) |-> !irq_o);
endmodule

// File: rtl/rxr_ring_top.sv
// Receive descriptor ring top: ties admission, storage and interrupts together.
// Assumes software and the frame source share one clock.
module rxr_ring_top #(
    parameter int NUM_DESC  = 8,
    parameter int BUF_BYTES = 2,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
    localparam int LEN_W    = $clog2(BUF_BYTES + 1),
    localparam int DATA_W   = BUF_BYTES * 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_en,
    input  logic                       frm_valid,
    input  logic [LEN_W-1:0]           frm_len,
    input  logic [DATA_W-1:0]          frm_data,
    input  logic [IDX_W-1:0]           sw_addr,
    input  logic                       sw_we,
    input  logic [rxr_pkg::DESC_W-1:0] sw_wdata,
    output logic [rxr_pkg::DESC_W-1:0] sw_rdata,
    output logic [DATA_W-1:0]          sw_buf_rdata,
    input  logic                       irq_clr_we,
    input  logic [rxr_pkg::SRC_W-1:0]  irq_clr_data,
    input  logic                       irq_mask_we,
    input  logic [rxr_pkg::SRC_W-1:0]  irq_mask_data,
    output logic [rxr_pkg::SRC_W-1:0]  irq_src,
    output logic                       irq,
    output logic [IDX_W-1:0]           rx_ptr
);
    import rxr_pkg::*;

    logic [NUM_DESC-1:0] empty_vec;
    logic                store, drop, en_err;
    logic [LEN_W-1:0]    st_len;
    logic [DATA_W-1:0]   st_data;
    logic [SRC_W-1:0]    src_set;

    rxr_ring_ctrl #(.NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
        .frm_valid(frm_valid), .frm_len(frm_len), .frm_data(frm_data),
        .empty_vec(empty_vec), .store_o(store), .drop_o(drop),
        .en_err_o(en_err), .ptr_o(rx_ptr), .len_o(st_len), .data_o(st_data)
    );

    rxr_desc_store #(.NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .sw_buf_rdata(sw_buf_rdata),
        .hw_we(store), .hw_idx(rx_ptr), .hw_len(st_len), .hw_data(st_data),
        .empty_vec(empty_vec)
    );

    // Collect the per-cycle source events.
    always_comb begin
        src_set           = '0;
        src_set[SRC_RX]   = store;
        src_set[SRC_BUSY] = drop;
        src_set[SRC_ERR]  = en_err;
    end

    rxr_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(src_set),
        .clr_we(irq_clr_we), .clr_data(irq_clr_data),
        .mask_we(irq_mask_we), .mask_data(irq_mask_data),
        .src_o(irq_src), .irq_o(irq)
    );

    // R5
    // busy_latch_chk
    busy_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && rx_en && !empty_vec[rx_ptr]) |=> irq_src[SRC_BUSY]);
endmodule

// File: tb/tb_rxr_ring_top.sv
module tb_rxr_ring_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_en, frm_valid, sw_we, irq_clr_we, irq_mask_we;
    logic [1:0]  frm_len;
    logic [15:0] frm_data, sw_wdata, sw_rdata, sw_buf_rdata;
    logic [2:0]  sw_addr, irq_clr_data, irq_mask_data, irq_src, rx_ptr;
    logic        irq;
    int          n_tests = 0;
    int          n_fail  = 0;

    always #5 clk = ~clk;

    rxr_ring_top dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frm_valid(frm_valid),
        .frm_len(frm_len), .frm_data(frm_data), .sw_addr(sw_addr),
        .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .sw_buf_rdata(sw_buf_rdata), .irq_clr_we(irq_clr_we),
        .irq_clr_data(irq_clr_data), .irq_mask_we(irq_mask_we),
        .irq_mask_data(irq_mask_data), .irq_src(irq_src), .irq(irq),
        .rx_ptr(rx_ptr)
    );

    // Frame vectors: {length, payload}; entry k lands in descriptor k.
    localparam logic [17:0] FRAMES [0:7] = '{
        {2'd2, 16'hA1B2}, {2'd1, 16'hC3D4}, {2'd0, 16'hFFFF}, {2'd3, 16'h1234},
        {2'd2, 16'h0F0F}, {2'd1, 16'h5566}, {2'd2, 16'h8001}, {2'd3, 16'h7E7E}};

    function automatic logic [1:0] exp_len(input logic [1:0] l);
        return (l > 2'd2) ? 2'd2 : l;
    endfunction

    function automatic logic [15:0] exp_buf(input logic [1:0] l, input logic [15:0] d);
        case (exp_len(l))
            2'd0:    return 16'h0000;
            2'd1:    return {8'h00, d[7:0]};
            default: return d;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic sw_write(input logic [2:0] a, input logic [15:0] w);
        sw_addr = a; sw_wdata = w; sw_we = 1'b1;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic frame(input logic [1:0] l, input logic [15:0] d);
        frm_len = l; frm_data = d; frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic clear_src(input logic [2:0] c);
        irq_clr_data = c; irq_clr_we = 1'b1;
        @(negedge clk);
        irq_clr_we = 1'b0;
    endtask

    task automatic set_mask(input logic [2:0] m);
        irq_mask_data = m; irq_mask_we = 1'b1;
        @(negedge clk);
        irq_mask_we = 1'b0;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_en = 1'b0; frm_valid = 1'b0; frm_len = '0; frm_data = '0;
        sw_addr = '0; sw_we = 1'b0; sw_wdata = '0; irq_clr_we = 1'b0;
        irq_clr_data = '0; irq_mask_we = 1'b0; irq_mask_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "ptr", 32'(rx_ptr), 0);
        check("R1", "src", 32'(irq_src), 0);
        check("R1", "irq", 32'(irq), 0);
        sw_addr = 3'd5;
        #1 check("R1", "desc5", 32'(sw_rdata), 0);
        check("R1", "buf5", 32'(sw_buf_rdata), 0);

        // R9 enable with no empty descriptor raises error
        rx_en = 1'b1;
        @(negedge clk);
        check("R9", "err src", 32'(irq_src), 32'h4);
        // R8 write-one clears only the written bit
        clear_src(3'b011);
        check("R8", "w1c other bits", 32'(irq_src), 32'h4);
        clear_src(3'b100);
        check("R8", "w1c clear", 32'(irq_src), 0);

        // R6 frames ignored while disabled
        rx_en = 1'b0;
        sw_write(3'd0, 16'h8010);
        frame(2'd2, 16'hBEEF);
        sw_addr = 3'd0;
        #1 check("R6", "desc0", 32'(sw_rdata), 32'h8010);
        check("R6", "buf0", 32'(sw_buf_rdata), 0);
        check("R6", "ptr", 32'(rx_ptr), 0);
        check("R6", "src", 32'(irq_src), 0);

        // R2 arm every descriptor and read back
        for (int i = 0; i < 8; i++) sw_write(3'(i), 16'h8000 | 16'(i << 4));
        for (int i = 0; i < 8; i++) begin
            sw_addr = 3'(i);
            #1 check("R2", "armed desc", 32'(sw_rdata), 32'h8000 | 32'(i << 4));
        end

        // R9 enable with empty entries raises no error
        rx_en = 1'b1;
        @(negedge clk);
        check("R9", "no err", 32'(irq_src), 0);

        // R3 R4 R7 walk the frame table
        for (int k = 0; k < 8; k++) begin
            frame(FRAMES[k][17:16], FRAMES[k][15:0]);
            sw_addr = 3'(k);
            #1 check("R3", "desc", 32'(sw_rdata),
                     32'(16'(k << 4) | 16'(exp_len(FRAMES[k][17:16]))));
            check("R3", "buf", 32'(sw_buf_rdata),
                  32'(exp_buf(FRAMES[k][17:16], FRAMES[k][15:0])));
            check("R4", "ptr", 32'(rx_ptr), 32'((k + 1) % 8));
            check("R7", "rx src masked", 32'(irq_src[0]), 1);
            check("R7", "irq masked", 32'(irq), 0);
        end

        // R5 ring full: drop and busy
        clear_src(3'b001);
        frame(2'd2, 16'hDEAD);
        sw_addr = 3'd0;
        #1 check("R5", "busy src", 32'(irq_src), 32'h2);
        check("R5", "ptr held", 32'(rx_ptr), 0);
        check("R5", "desc0 held", 32'(sw_rdata), 32'h0002);
        check("R5", "buf0 held", 32'(sw_buf_rdata), 32'hA1B2);

        // R10 R7 mask drives interrupt
        set_mask(3'b001);
        check("R10", "irq busy unmasked", 32'(irq), 0);
        set_mask(3'b010);
        check("R10", "irq busy masked in", 32'(irq), 1);
        clear_src(3'b010);
        check("R7", "irq after clear", 32'(irq), 0);

        // R8 store and clear in same cycle: set wins
        set_mask(3'b001);
        sw_write(3'd0, 16'h8000);
        frame(2'd1, 16'h0042);
        check("R7", "irq on store", 32'(irq), 1);
        sw_write(3'd1, 16'h8000);
        irq_clr_data = 3'b001; irq_clr_we = 1'b1;
        frm_len = 2'd2; frm_data = 16'h9988; frm_valid = 1'b1;
        @(negedge clk);
        irq_clr_we = 1'b0; frm_valid = 1'b0;
        check("R8", "set beats clear", 32'(irq_src[0]), 1);
        check("R4", "ptr after wrap", 32'(rx_ptr), 2);
        sw_addr = 3'd1;
        #1 check("R3", "buf1 stored", 32'(sw_buf_rdata), 32'h9988);
        clear_src(3'b001);
        check("R8", "plain clear", 32'(irq_src[0]), 0);
        idle_cycle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule